// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DDR SDRAM controller owes the memory an auto-refresh, and it governs the move into and out of self-refresh. A free-running interval timer, measured in controller clocks, adds one owed refresh each time the average refresh interval elapses. The owed refreshes build up in a saturating backlog, so the controller can postpone refreshes while its command path is busy. It must pay them off before the backlog reaches its ceiling. Once the backlog reaches a set level the request is flagged urgent, and the controller's arbiter should then give refresh top priority.

Every time limit is given in nanoseconds and turned into whole clocks by rounding up against the clock-period parameter. After each granted refresh the block lowers its non-read ready flag for the refresh cycle time. After leaving self-refresh it keeps two separate waits: a short one for non-read commands and a long one, counted directly in clocks, for reads. While the memory is in self-refresh the block requests nothing and holds both ready flags low. The backlog and the interval timer restart from zero, because the device refreshes itself during that time. Self-refresh is also the only state in which the controller may change its clock frequency.

Top module: `rfsh_sched`

## Requirements
- R1: After reset the block is in normal mode, `ref_req` and `ref_urgent` are low, `nonrd_ok` and `rd_ok` are high, and `sr_active` is low.
- R2: In normal mode the backlog gains one every REFI_CYC = ceil(REFI_NS*1000/CLK_PERIOD_PS) clocks (975 by default). `ref_req` is high whenever the backlog is non-zero and neither the refresh-cycle wait nor the non-read exit wait is running.
- R3: A `ref_grant` taken while `ref_req` is high lowers the backlog by one. A grant while `ref_req` is low is ignored. A grant in the same clock as an interval expiry leaves the backlog unchanged.
- R4: `ref_urgent` is high exactly while the backlog is at or above URGENT_AT (8 by default).
- R5: The backlog saturates at MAX_POSTPONE (8). An interval expiry at the ceiling without a grant is lost.
- R6: After an accepted grant, `nonrd_ok` and `ref_req` stay low for RFC_CYC = ceil(RFC_NS*1000/CLK_PERIOD_PS) clocks (9 by default).
- R7: `sr_enter` is accepted only in normal mode, with no refresh-cycle wait running and no grant taken in the same clock. Acceptance sets `sr_active` on the next clock and clears the backlog and the interval timer. While `sr_active` is high, `ref_req`, `nonrd_ok` and `rd_ok` are low and the backlog does not grow.
- R8: After an accepted `sr_exit`, `nonrd_ok` stays low for XSNR_CYC = max(ceil(XSNR_NS*1000/CLK_PERIOD_PS), RFC_CYC+1) clocks (10 by default).
- R9: After an accepted `sr_exit`, `rd_ok` stays low for XSRD_CLKS clocks (200 by default).
- R10: `sr_exit` in normal mode and `sr_enter` in self-refresh have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Controller issued the requested auto-refresh this clock |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | An auto-refresh is owed and may be issued now |
| ref_urgent | output | 1 | Backlog has reached the urgent level |
| nonrd_ok | output | 1 | Non-read commands (including activate) are permitted |
| rd_ok | output | 1 | Read commands are permitted |
| sr_active | output | 1 | Memory is held in self-refresh |

## Verification
The first stimulus lets the interval timer run untouched with a grant pulsed while nothing is owed. This separates a correct expiry period from an off-by-one count and shows whether an unrequested grant is ignored. The next pattern times a grant onto the exact clock of an interval expiry, then leaves refreshes unpaid for more than eight intervals and drains them. Together these tell a correct net-zero update apart from a lost or doubled credit, and saturation apart from wraparound. The self-refresh pattern tries entry during a refresh-cycle wait, entry in the same clock as a grant, a clean entry, a long stay, and an exit. It measures the non-read and read release points separately, so swapped or shared exit waits are caught.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [0:0] {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } rfsh_mode_e;

  // Integer ceiling division.
  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Nanoseconds to whole clocks, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    return cdiv(ns * 1000, period_ps);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value v.
  function automatic int bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  // Selects one of three loads by index (used by the wait-timer generate loop).
  function automatic int unsigned pick3(input int idx, input int unsigned a,
                                        input int unsigned b, input int unsigned c);
    return (idx == 0) ? a : ((idx == 1) ? b : c);
  endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int unsigned PERIOD = 975,
  parameter int          IW     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [IW-1:0] phase_q;
  logic          at_end;

  assign at_end = (phase_q == IW'(PERIOD - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!run)    phase_q <= '0;
    else if (at_end)  phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int unsigned MAX_LVL = 8,
  parameter int unsigned URG_LVL = 8,
  parameter int          CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          take,
  output logic [CW-1:0] level,
  output logic          urgent
);

  logic [CW-1:0] level_d;

  always_comb begin
    int sum;
    sum = int'(level) + (tick ? 1 : 0) - (take ? 1 : 0);
    if (sum > int'(MAX_LVL)) sum = int'(MAX_LVL);
    if (sum < 0)             sum = 0;
    level_d = CW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level <= '0;
    else if (clr) level <= '0;
    else          level <= level_d;
  end

  assign urgent = (level >= CW'(URG_LVL));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(MAX_LVL));

  // R2
  tick_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !take && !clr && (level < CW'(MAX_LVL)) |=> level == $past(level) + 1'b1);

  // R3
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !tick && !clr |=> level == $past(level) - 1'b1);

  // R3
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && take && !clr |=> $stable(level));

  // R7
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> level == '0);

endmodule

// File: rtl/rfsh_delay.sv
module rfsh_delay #(
  parameter int unsigned LOAD = 9,
  parameter int          DW   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);

  logic [DW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (clr)         left_q <= '0;
    else if (load)        left_q <= DW'(LOAD);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // R6
  load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> left_q == DW'(LOAD));

  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load && !clr |=> left_q == $past(left_q) - 1'b1);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned REFI_NS       = 7800,
  parameter int unsigned RFC_NS        = 70,
  parameter int unsigned XSNR_NS       = 75,
  parameter int unsigned XSRD_CLKS     = 200,
  parameter int unsigned MAX_POSTPONE  = 8,
  parameter int unsigned URGENT_AT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic ref_req,
  output logic ref_urgent,
  output logic nonrd_ok,
  output logic rd_ok,
  output logic sr_active
);

  localparam int unsigned REFI_CYC = ns_to_cyc(REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC  = ns_to_cyc(RFC_NS, CLK_PERIOD_PS);
  localparam int unsigned XSNR_CYC = max2(ns_to_cyc(XSNR_NS, CLK_PERIOD_PS), RFC_CYC + 1);
  localparam int unsigned XSRD_CYC = XSRD_CLKS;
  localparam int          IW       = bits_for(REFI_CYC - 1);
  localparam int          CW       = bits_for(MAX_POSTPONE);
  localparam int          DW       = bits_for(max2(max2(RFC_CYC, XSNR_CYC), XSRD_CYC));
  localparam int          NWAIT    = 3;   // 0: refresh cycle, 1: non-read exit, 2: read exit

  rfsh_mode_e    mode_q;
  logic          run;
  logic          tick;
  logic [CW-1:0] level;
  logic          grant_acc;
  logic          enter_acc;
  logic          exit_acc;
  logic [NWAIT-1:0] wait_busy;
  logic [NWAIT-1:0] wait_load;
  logic [NWAIT-1:0] wait_clr;

  assign run       = (mode_q == MODE_RUN);
  assign ref_req   = run && (level != '0) && !wait_busy[0] && !wait_busy[1];
  assign grant_acc = ref_grant && ref_req;
  assign enter_acc = sr_enter && run && !wait_busy[0] && !grant_acc;
  assign exit_acc  = sr_exit && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_RUN;
    else if (enter_acc) mode_q <= MODE_SELF;
    else if (exit_acc)  mode_q <= MODE_RUN;
  end

  rfsh_interval #(.PERIOD(REFI_CYC), .IW(IW)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run && !enter_acc),
    .tick  (tick)
  );

  rfsh_credit #(.MAX_LVL(MAX_POSTPONE), .URG_LVL(URGENT_AT), .CW(CW)) u_credit (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (enter_acc),
    .tick   (tick),
    .take   (grant_acc),
    .level  (level),
    .urgent (ref_urgent)
  );

  assign wait_load = {exit_acc, exit_acc, grant_acc};
  assign wait_clr  = {NWAIT{enter_acc}};

  for (genvar g = 0; g < NWAIT; g++) begin : g_wait
    rfsh_delay #(.LOAD(pick3(g, RFC_CYC, XSNR_CYC, XSRD_CYC)), .DW(DW)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wait_clr[g]),
      .load  (wait_load[g]),
      .busy  (wait_busy[g])
    );
  end

  assign nonrd_ok  = run && !wait_busy[0] && !wait_busy[1];
  assign rd_ok     = run && !wait_busy[2];
  assign sr_active = !run;

  // R6
  grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_acc |=> !nonrd_ok && !ref_req);

  // R7
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_req && !nonrd_ok && !rd_ok && !ref_urgent);

  // R7
  enter_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_acc |=> sr_active);

  // R8
  exit_nonrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_acc |=> !sr_active && !nonrd_ok && !ref_req);

  // R9
  exit_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_acc |=> !rd_ok);

  // R10
  self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active && !sr_exit |=> sr_active);

  // R4
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> run && (level != '0));

endmodule

// File: tb/rfsh_sched_test.sv
`timescale 1ns/1ps
module rfsh_sched_test;

  localparam int PER_PS = 8000;
  localparam int REFI   = (7800 * 1000 + PER_PS - 1) / PER_PS;
  localparam int RFC    = (70 * 1000 + PER_PS - 1) / PER_PS;
  localparam int XSNR_R = (75 * 1000 + PER_PS - 1) / PER_PS;
  localparam int XSNR   = (XSNR_R > RFC + 1) ? XSNR_R : RFC + 1;
  localparam int XSRD   = 200;
  localparam int MAXP   = 8;
  localparam int URG    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_urgent, nonrd_ok, rd_ok, sr_active;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rfsh_sched uut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .nonrd_ok(nonrd_ok), .rd_ok(rd_ok), .sr_active(sr_active)
  );

  // Behavioural reference model
  int m_iv, m_pend, m_rfc, m_xsnr, m_xsrd;
  bit m_sr;
  bit m_req, m_g, m_tick;

  function automatic bit e_req();   return !m_sr && m_pend > 0 && m_rfc == 0 && m_xsnr == 0; endfunction
  function automatic bit e_urg();   return m_pend >= URG; endfunction
  function automatic bit e_nonrd(); return !m_sr && m_rfc == 0 && m_xsnr == 0; endfunction
  function automatic bit e_rd();    return !m_sr && m_xsrd == 0; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_iv = 0; m_pend = 0; m_rfc = 0; m_xsnr = 0; m_xsrd = 0; m_sr = 0;
    end else if (m_sr) begin
      if (sr_exit) begin
        m_sr = 0; m_xsnr = XSNR; m_xsrd = XSRD;
      end
    end else begin
      m_req = e_req();
      m_g   = ref_grant && m_req;
      if (sr_enter && m_rfc == 0 && !m_g) begin
        m_sr = 1; m_pend = 0; m_iv = 0; m_xsnr = 0; m_xsrd = 0;
      end else begin
        m_tick = (m_iv == REFI - 1);
        m_iv   = m_tick ? 0 : m_iv + 1;
        m_pend = m_pend + (m_tick ? 1 : 0) - (m_g ? 1 : 0);
        if (m_pend > MAXP) m_pend = MAXP;
        m_rfc  = m_g ? RFC : ((m_rfc > 0) ? m_rfc - 1 : 0);
        if (m_xsnr > 0) m_xsnr = m_xsnr - 1;
        if (m_xsrd > 0) m_xsrd = m_xsrd - 1;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 ref_req",    ref_req,    e_req());
      check("R4 ref_urgent", ref_urgent, e_urg());
      check("R6 nonrd_ok",   nonrd_ok,   e_nonrd());
      check("R9 rd_ok",      rd_ok,      e_rd());
      check("R7 sr_active",  sr_active,  m_sr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grant_once();
    while (!ref_req) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  initial begin
    step(4);
    check("R1 ref_req",    ref_req,    1'b0);
    check("R1 ref_urgent", ref_urgent, 1'b0);
    check("R1 nonrd_ok",   nonrd_ok,   1'b1);
    check("R1 rd_ok",      rd_ok,      1'b1);
    check("R1 sr_active",  sr_active,  1'b0);
    rst_n = 1'b1;

    // R3: grant with nothing owed is ignored; R2: first request after REFI clocks
    ref_grant = 1'b1;
    step(1);
    ref_grant = 1'b0;
    step(REFI - 2);
    check("R2 no request before interval", ref_req, 1'b0);
    step(1);
    check("R2 request at interval", ref_req, 1'b1);

    // R6: refresh cycle wait
    ref_grant = 1'b1;
    step(1);
    ref_grant = 1'b0;
    for (int k = 1; k <= RFC; k++) begin
      check("R6 nonrd_ok low in tRFC", nonrd_ok, 1'b0);
      step(1);
    end
    check("R6 nonrd_ok back", nonrd_ok, 1'b1);

    // R3: grant on the expiry clock with one owed
    while (!(m_iv == REFI - 1 && m_pend == 1 && ref_req)) step(1);
    ref_grant = 1'b1;
    step(1);
    ref_grant = 1'b0;
    step(RFC);
    check("R3 tick+grant keeps backlog", ref_req, 1'b1);
    grant_once();
    step(RFC + 1);

    // R4 / R5: build past the ceiling, then drain
    step(9 * REFI + 5);
    check("R4 urgent at ceiling", ref_urgent, 1'b1);
    while (m_iv != 1) step(1);
    grant_once();
    step(1);
    check("R4 urgent drops below level", ref_urgent, 1'b0);
    for (int k = 0; k < 7; k++) grant_once();
    step(RFC + 1);
    check("R5 only eight refreshes owed", ref_req, 1'b0);

    // R7: entry refused during tRFC and alongside a grant
    while (m_pend < 2) step(1);
    grant_once();
    sr_enter = 1'b1;
    step(1);
    sr_enter = 1'b0;
    check("R7 entry refused in tRFC", sr_active, 1'b0);
    step(RFC + 1);
    ref_grant = 1'b1;
    sr_enter  = 1'b1;
    step(1);
    ref_grant = 1'b0;
    sr_enter  = 1'b0;
    check("R7 entry refused with grant", sr_active, 1'b0);
    step(RFC + 1);
    sr_enter = 1'b1;
    step(1);
    sr_enter = 1'b0;
    check("R7 entry taken", sr_active, 1'b1);
    check("R7 rd_ok low in self-refresh", rd_ok, 1'b0);
    sr_enter = 1'b1;
    step(1);
    sr_enter = 1'b0;
    step(3 * REFI);
    check("R7 no request in self-refresh", ref_req, 1'b0);
    check("R10 still in self-refresh", sr_active, 1'b1);

    // R8 / R9: exit waits
    sr_exit = 1'b1;
    step(1);
    sr_exit = 1'b0;
    check("R8 nonrd_ok low after exit", nonrd_ok, 1'b0);
    step(XSNR - 1);
    check("R8 nonrd_ok low at last wait clock", nonrd_ok, 1'b0);
    step(1);
    check("R8 nonrd_ok released", nonrd_ok, 1'b1);
    check("R7 backlog cleared", ref_req, 1'b0);
    check("R9 rd_ok still low", rd_ok, 1'b0);
    step(XSRD - XSNR - 1);
    check("R9 rd_ok low at last wait clock", rd_ok, 1'b0);
    step(1);
    check("R9 rd_ok released", rd_ok, 1'b1);

    // R10: exit in normal mode ignored
    sr_exit = 1'b1;
    step(1);
    sr_exit = 1'b0;
    check("R10 exit in normal mode ignored", rd_ok, 1'b1);
    check("R10 sr_active stays low", sr_active, 1'b0);
    step(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule